// File: doc/BRIEF.md
# I2C Transmit Bit Timing Sequencer

This block paces one transmitted data bit of an I2C transmitter. It watches the SCL line through a two-flop synchronizer. When it sees a falling edge, it pulls SCL low at once and keeps it low. It then waits a programmable data-hold interval and puts the next bit on SDA. After that it waits a programmable data-setup interval and lets SCL go again. If the data bit is not ready when the hold interval ends, the block goes on stretching SCL until the transmit-valid flag comes. The setup interval starts only once the bit is on the line.

Both intervals are counted in units of a prescaled clock. One unit is `presc+1` kernel clock cycles. The hold interval is `holdDly` units and the setup interval is `setupDly+1` units. The outputs are open-drain enables: a 1 pulls the line low and a 0 releases it. Each delay phase spends one more kernel cycle on its decision, so a phase of N units takes N*(presc+1)+1 cycles.

Top module: `i2c_bit_timer`

## Requirements
- R1: Synchronous active-low reset releases both lines (`sclOe`=0, `sdaOe`=0) at the next rising clock edge, even in the middle of a sequence.
- R2: With the block idle, an SCL high-to-low transition first sampled low at rising edge k makes `sclOe` 1 after edge k+2. SCL staying high never asserts `sclOe`.
- R3: If `txValid` is already 1, `sdaOe` takes its new value at edge k+3+holdDly*(presc+1). This holds for holdDly=0 too, where the new value comes at edge k+3.
- R4: The driven value is `sdaOe` = NOT `txBit`, with `txBit` sampled at the drive edge. `txBit`=0 pulls SDA low (`sdaOe`=1), and `txBit`=1 releases it (`sdaOe`=0).
- R5: If `txValid` is 0 when the hold interval ends, `sclOe` stays 1 and `sdaOe` stays unchanged for as long as the flag stays low. The bit is driven at the first rising edge that samples `txValid`=1.
- R6: `sclOe` returns to 0 exactly (setupDly+1)*(presc+1)+1 cycles after the edge that drove the bit. It stays 1 without a break from detection until then.
- R7: After release, the block does nothing until the next synchronized SCL falling edge. SCL held low by another device does not retrigger it.
- R8: Changes on `txBit` or `txValid` after the drive edge do not alter `sdaOe` until the next drive edge.
- R9: `sdaOe` changes only while `sclOe` is 1 on both sides of the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Synchronous reset, active low |
| presc | input | CFG_W | Prescaler: one unit = presc+1 cycles |
| holdDly | input | CFG_W | Data hold interval in units |
| setupDly | input | CFG_W | Data setup interval, setupDly+1 units |
| txValid | input | 1 | Transmit data bit is available |
| txBit | input | 1 | Data bit to transmit |
| sclIn | input | 1 | SCL line level (asynchronous) |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that `presc`, `holdDly` and `setupDly` stay constant from a detected SCL fall until the release. They also assume that SCL, once it falls, stays low for the two synchronizer cycles. The exact interval checks count cycles against the configuration inputs, so a setting that changed mid-sequence would break them. For the same reason, a glitch on SCL would break the check that ties the `sclOe` rise to a low line. The bench changes configuration only while SCL is high and the block is idle. It lowers SCL only at a falling clock edge and keeps it low until the block has released it.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAIT,
    ST_SETUP
  } btState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setScl;   // start stretching SCL
    logic clrCnt;   // restart prescaler and unit counter
    logic loadSda;  // drive txBit onto SDA
    logic relScl;   // release SCL
  } btStrb_t;

endpackage

// File: rtl/i2c_bt_datapath.sv
module i2c_bt_datapath
  import i2c_bt_pkg::*;
#(
  parameter int CFG_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] presc,
  input  logic [CFG_W-1:0] holdDly,
  input  logic [CFG_W-1:0] setupDly,
  input  logic             txBit,
  input  logic             sclIn,
  input  btStrb_t          strb,
  output logic             fallSeen,
  output logic             holdDone,
  output logic             setupDone,
  output logic             sclOe,
  output logic             sdaOe
);

  localparam int UNIT_W = CFG_W + 1;

  logic [SYNC_N-1:0] syncQ;
  logic              prevQ;
  logic [CFG_W-1:0]  prescCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic              tick;

  // input synchronizer and fall detector, idle level is high
  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= sclIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_N-2:0], sclIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[SYNC_N-1];
  end

  assign fallSeen = prevQ & ~syncQ[SYNC_N-1];

  // prescaled time base
  assign tick = (prescCnt == presc);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCnt) begin
      prescCnt <= '0;
      unitCnt  <= '0;
    end else begin
      if (tick) begin
        prescCnt <= '0;
        if (unitCnt != '1) unitCnt <= unitCnt + UNIT_W'(1);
      end else begin
        prescCnt <= prescCnt + CFG_W'(1);
      end
    end
  end

  assign holdDone  = (unitCnt == {1'b0, holdDly});
  assign setupDone = (unitCnt == ({1'b0, setupDly} + UNIT_W'(1)));

  // open-drain enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      if (strb.setScl)      sclOe <= 1'b1;
      else if (strb.relScl) sclOe <= 1'b0;
      if (strb.loadSda)     sdaOe <= ~txBit;
    end
  end

endmodule

// File: rtl/i2c_bt_ctrl.sv
module i2c_bt_ctrl
  import i2c_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fallSeen,
  input  logic    holdDone,
  input  logic    setupDone,
  input  logic    txValid,
  output btStrb_t strb
);

  btState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (fallSeen) begin
          strb.setScl = 1'b1;
          strb.clrCnt = 1'b1;
          stateNxt    = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (holdDone) begin
          if (txValid) begin
            strb.loadSda = 1'b1;
            strb.clrCnt  = 1'b1;
            stateNxt     = ST_SETUP;
          end else begin
            stateNxt = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (txValid) begin
          strb.loadSda = 1'b1;
          strb.clrCnt  = 1'b1;
          stateNxt     = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (setupDone) begin
          strb.relScl = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int CFG_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] presc,
  input  logic [CFG_W-1:0] holdDly,
  input  logic [CFG_W-1:0] setupDly,
  input  logic             txValid,
  input  logic             txBit,
  input  logic             sclIn,
  output logic             sclOe,
  output logic             sdaOe
);

  btStrb_t strb;
  logic    fallSeen;
  logic    holdDone;
  logic    setupDone;

  i2c_bt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fallSeen (fallSeen),
    .holdDone (holdDone),
    .setupDone(setupDone),
    .txValid  (txValid),
    .strb     (strb)
  );

  i2c_bt_datapath #(.CFG_W(CFG_W), .SYNC_N(SYNC_N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .presc    (presc),
    .holdDly  (holdDly),
    .setupDly (setupDly),
    .txBit    (txBit),
    .sclIn    (sclIn),
    .strb     (strb),
    .fallSeen (fallSeen),
    .holdDone (holdDone),
    .setupDone(setupDone),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe)
  );

endmodule

// File: rtl/i2c_bt_checker.sv
module i2c_bt_checker #(
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] presc,
  input logic [CFG_W-1:0] holdDly,
  input logic [CFG_W-1:0] setupDly,
  input logic             txValid,
  input logic             sclIn,
  input logic             sclOe,
  input logic             sdaOe,
  input logic             setScl,
  input logic             loadSda,
  input logic             relScl
);

  localparam int SAT = 1000000;

  int phaseCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                  phaseCnt <= 0;
    else if (setScl || loadSda) phaseCnt <= 0;
    else if (phaseCnt < SAT)    phaseCnt <= phaseCnt + 1;
  end

  // R1
  reset_release_chk: assert property (@(posedge clk)
    !rstN |=> (!sclOe && !sdaOe));

  // R2
  rise_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> (!$past(sclIn) && !$past(sclIn, 2)));

  // R3
  hold_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadSda |-> (phaseCnt >= int'(holdDly) * (int'(presc) + 1)));

  // R6
  setup_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    relScl |-> (phaseCnt == (int'(setupDly) + 1) * (int'(presc) + 1)));

  // R9
  sda_under_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> (sclOe && $past(sclOe)));

  // R5
  sda_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> $past(txValid));

endmodule

bind i2c_bit_timer i2c_bt_checker #(.CFG_W(CFG_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .presc   (presc),
  .holdDly (holdDly),
  .setupDly(setupDly),
  .txValid (txValid),
  .sclIn   (sclIn),
  .sclOe   (sclOe),
  .sdaOe   (sdaOe),
  .setScl  (strb.setScl),
  .loadSda (strb.loadSda),
  .relScl  (strb.relScl)
);

// File: tb/sim_i2c_bit_timer.sv
`timescale 1ns/1ps
module sim_i2c_bit_timer;

  localparam int CFG_W = 4;
  localparam int NV    = 8;
  // presc, holdDly, setupDly, lateData
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 0},
    '{0, 3, 1, 0},
    '{2, 2, 0, 0},
    '{1, 0, 3, 0},
    '{3, 4, 2, 0},
    '{0, 2, 0, 1},
    '{15, 15, 15, 0},
    '{4, 1, 5, 1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CFG_W-1:0] presc = '0, holdDly = '0, setupDly = '0;
  logic txValid = 1'b0, txBit = 1'b1, sclIn = 1'b1;
  logic sclOe, sdaOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2c_bit_timer #(.CFG_W(CFG_W)) u0 (
    .clk(clk), .rstN(rstN), .presc(presc), .holdDly(holdDly),
    .setupDly(setupDly), .txValid(txValid), .txBit(txBit),
    .sclIn(sclIn), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one SCL fall, measured in negedges after the fall (neg 0)
  task automatic runOne(input int p, input int h, input int s, input int late,
                        input bit b, output int riseAt, output int chgAt,
                        output int relAt);
    int lateAt;
    logic prevSda;
    lateAt = h * (p + 1) + 10;
    @(negedge clk);
    presc = p[CFG_W-1:0]; holdDly = h[CFG_W-1:0]; setupDly = s[CFG_W-1:0];
    txBit = b; txValid = (late == 0); sclIn = 1'b1;
    repeat (4) @(negedge clk);
    prevSda = sdaOe;
    sclIn = 1'b0;
    riseAt = -1; chgAt = -1; relAt = -1;
    for (int j = 1; j < 3000; j++) begin
      @(negedge clk);
      if (riseAt < 0 && sclOe) riseAt = j;
      if (chgAt < 0 && sdaOe != prevSda) chgAt = j;
      if (riseAt >= 0 && relAt < 0 && !sclOe) relAt = j;
      if (late != 0 && j == lateAt) txValid = 1'b1;
      if (relAt >= 0) break;
    end
  endtask

  initial begin
    int ra, ca, la, expChg, expRel, p, h, s, late;
    bit b;
    bit stayedLow;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclOe == 1'b0, "R1 sclOe in reset", sclOe, 0);
    chk(sdaOe == 1'b0, "R1 sdaOe in reset", sdaOe, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    // R2 SCL idle high does nothing
    chk(sclOe == 1'b0, "R2 no action while SCL high", sclOe, 0);

    for (int i = 0; i < NV; i++) begin
      p = VEC[i][0]; h = VEC[i][1]; s = VEC[i][2]; late = VEC[i][3];
      b = (i % 2 == 0) ? 1'b0 : 1'b1;
      runOne(p, h, s, late, b, ra, ca, la);
      expChg = 4 + h * (p + 1);
      if (late != 0) expChg = h * (p + 1) + 11;
      expRel = expChg + (s + 1) * (p + 1) + 1;
      chk(ra == 3, "R2 sclOe rise timing", ra, 3);
      if (late != 0) chk(ca == expChg, "R5 late data drive timing", ca, expChg);
      else           chk(ca == expChg, "R3 hold timing", ca, expChg);
      chk(sdaOe == ~b, "R4 driven value", sdaOe, ~b);
      chk(la == expRel, "R6 setup release timing", la, expRel);
      @(negedge clk);
      txValid = 1'b0; sclIn = 1'b1;
    end

    // R8: change txBit/txValid after drive; R7: SCL kept low after release
    runOne(3, 1, 5, 0, 1'b0, ra, ca, la);
    // already released here; sdaOe should be 1 from txBit=0
    chk(sdaOe == 1'b1, "R4 bit0 pulls SDA", sdaOe, 1);
    // redo a sequence and toggle inputs in the setup phase
    @(negedge clk); sclIn = 1'b1; txBit = 1'b1; txValid = 1'b1;
    repeat (4) @(negedge clk);
    sclIn = 1'b0;
    repeat (4 + 1 * 4 + 2) @(negedge clk);
    chk(sdaOe == 1'b0 && sclOe == 1'b1, "R8 bit1 driven, SCL held", {sdaOe, sclOe}, 1);
    txBit = 1'b0; txValid = 1'b0;
    repeat (30) @(negedge clk);
    chk(sclOe == 1'b0, "R6 released after setup", sclOe, 0);
    chk(sdaOe == 1'b0, "R8 sdaOe unaffected by later txBit", sdaOe, 0);
    txValid = 1'b1;
    stayedLow = 1'b1;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (sclOe) stayedLow = 1'b0;
    end
    chk(stayedLow, "R7 no retrigger while SCL stays low", stayedLow, 1);
    chk(sdaOe == 1'b0, "R8 sdaOe unchanged with valid after release", sdaOe, 0);

    // R5: data never arrives, SCL stretched indefinitely
    txValid = 1'b0; txBit = 1'b0; sclIn = 1'b1;
    repeat (5) @(negedge clk);
    sclIn = 1'b0;
    repeat (150) @(negedge clk);
    chk(sclOe == 1'b1, "R5 SCL stretched without data", sclOe, 1);
    chk(sdaOe == 1'b0, "R5 SDA unchanged without data", sdaOe, 0);

    // R1: reset mid-sequence
    rstN = 1'b0;
    @(negedge clk);
    chk(sclOe == 1'b0 && sdaOe == 1'b0, "R1 mid-sequence reset", {sclOe, sdaOe}, 0);
    sclIn = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(sclOe == 1'b0, "R1 idle after reset", sclOe, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule